// File: doc/BRIEF.md
# Accumulator Instruction Sequencer

This block is the control and data core of a small 16-bit single-accumulator processor. It holds a word-addressed program and data memory together with the working registers: program counter, address register, instruction register, data register, accumulator and a one-bit carry/extend flag. A step counter walks each instruction through up to seven timing steps. Each instruction is fetched and decoded, and the effective address is optionally resolved through one level of indirection. The block then executes one of seven memory-reference operations: bitwise AND, add with carry, load, store, unconditional branch, branch-and-save-return, and increment-and-skip-if-zero.

Instructions with opcode 7 are not executed here. They end after the decode steps, and the block raises a one-cycle dispatch strobe so that neighbouring logic can carry out register-class or I/O-class work. The strobe chosen depends on the indirect bit. A run flip-flop, set by `start` and cleared by `stop`, gates the step counter. While it is clear nothing advances, and a host port may load or inspect memory.

Top module: `acc_seq`

## Requirements
- R1: After reset the run flag is clear and the step count, program counter, accumulator and extend flag are all zero.
- R2: A `start` pulse sets the run flag unless `stop` is high in the same cycle, since `stop` has priority. While the run flag is clear, the step count, program counter, accumulator and extend flag keep their values.
- R3: An instruction word carries the indirect flag in bit 15, the opcode in bits 14..12 and the address in bits 11..0. The program counter advances by one during fetch, and the step count returns to 0 when every instruction completes.
- R4: For opcodes 0..6 with bit 15 set, the operand address becomes the low 12 bits of the memory word at the instruction's address. This resolution happens inside the fixed step budget and adds no extra step.
- R5: AND (opcode 0) and ADD (opcode 1) each take 6 clock steps. AND leaves AC AND M in the accumulator. ADD leaves the 16-bit sum in the accumulator and its carry-out in the extend flag.
- R6: Load (opcode 2) takes 6 steps and copies the memory word into the accumulator. Store (opcode 3) takes 5 steps and writes the accumulator to memory.
- R7: Branch (opcode 4) takes 5 steps and sets PC to the effective address. Branch-and-save (opcode 5) takes 6 steps, writes the return PC to the effective address and continues at the effective address plus one.
- R8: Increment-and-skip (opcode 6) takes 7 steps and is the only instruction that reaches step 6. It writes the incremented word back to memory and advances PC by one more when the result is zero.
- R9: Opcode 7 takes 4 steps. It pulses `regref_stb` for one cycle when bit 15 is 0, or `io_stb` when bit 15 is 1, during step 3. The two strobes are never high together, and the instruction changes nothing but the fetch increment of PC.
- R10: A host write lands in memory only while the run flag is clear, and is ignored while running. `host_rdata` shows the word at `host_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Sets the run flag |
| stop | input | 1 | Clears the run flag; wins over start |
| host_we | input | 1 | Host memory write enable (honoured only while stopped) |
| host_addr | input | 12 | Host read/write address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Memory word at host_addr |
| running | output | 1 | Run flag |
| step | output | 3 | Current timing step |
| pc | output | 12 | Program counter |
| ac | output | 16 | Accumulator |
| e_flag | output | 1 | Extend/carry flag |
| ir | output | 16 | Instruction register |
| regref_stb | output | 1 | Register-class dispatch strobe |
| io_stb | output | 1 | I/O-class dispatch strobe |

## Verification
The assertions check the cycle-level invariants on every cycle. These are: state freezes while stopped, PC advances after the fetch step, the step never exceeds 6, and only increment-and-skip reaches step 6. They also check that dispatch strobes are exclusive, last one cycle, appear only at step 3 of opcode 7, and end the instruction. Only the bench's program can show arithmetic results, the carry into the extend flag, indirect resolution, the stored return address, the skip decision and per-instruction step counts. The same holds for memory contents after stores and the refusal of host writes while running.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

    typedef enum logic [2:0] {
        OP_AND = 3'd0,
        OP_ADD = 3'd1,
        OP_LDA = 3'd2,
        OP_STA = 3'd3,
        OP_BUN = 3'd4,
        OP_BSA = 3'd5,
        OP_ISZ = 3'd6,
        OP_EXT = 3'd7
    } opcode_e;

    localparam int unsigned N_OPCODES = 8;

endpackage

// File: rtl/acc_seq_mem.sv
module acc_seq_mem #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [WORD_W-1:0] rdata_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [WORD_W-1:0] rdata_b
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store_q[waddr] <= wdata;
        end
    end

    assign rdata_a = store_q[raddr_a];
    assign rdata_b = store_q[raddr_b];
endmodule

// File: rtl/acc_seq_timer.sv
module acc_seq_timer #(
    parameter int unsigned N_STEPS = 7
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         advance,
    input  logic                         clear,
    output logic [$clog2(N_STEPS)-1:0]   sc,
    output logic [N_STEPS-1:0]           t
);
    localparam int unsigned SC_W = $clog2(N_STEPS);

    logic [SC_W-1:0] sc_d, sc_q;

    always_comb begin
        sc_d = sc_q;
        if (advance) begin
            if (clear) begin
                sc_d = '0;
            end else begin
                sc_d = sc_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sc_q <= '0;
        end else begin
            sc_q <= sc_d;
        end
    end

    for (genvar k = 0; k < N_STEPS; k++) begin : g_step
        assign t[k] = (sc_q == SC_W'(k));
    end

    assign sc = sc_q;
endmodule

// File: rtl/acc_seq_opdec.sv
module acc_seq_opdec
    import acc_seq_pkg::*;
(
    input  logic [2:0]           op,
    output logic [N_OPCODES-1:0] d
);
    for (genvar k = 0; k < N_OPCODES; k++) begin : g_dec
        assign d[k] = (op == 3'(k));
    end
endmodule

// File: rtl/acc_seq.sv
module acc_seq
    import acc_seq_pkg::*;
#(
    parameter int unsigned WORD_W  = 16,
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned N_STEPS = 7
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic                        stop,
    input  logic                        host_we,
    input  logic [ADDR_W-1:0]           host_addr,
    input  logic [WORD_W-1:0]           host_wdata,
    output logic [WORD_W-1:0]           host_rdata,
    output logic                        running,
    output logic [$clog2(N_STEPS)-1:0]  step,
    output logic [ADDR_W-1:0]           pc,
    output logic [WORD_W-1:0]           ac,
    output logic                        e_flag,
    output logic [WORD_W-1:0]           ir,
    output logic                        regref_stb,
    output logic                        io_stb
);
    localparam int unsigned IND_BIT = WORD_W - 1;
    localparam int unsigned OP_HI   = WORD_W - 2;
    localparam int unsigned OP_LO   = WORD_W - 4;
    localparam int unsigned PAD_W   = WORD_W - ADDR_W;

    typedef struct packed {
        logic              run;
        logic              ind;
        logic              e;
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] ar;
        logic [WORD_W-1:0] ir;
        logic [WORD_W-1:0] dr;
        logic [WORD_W-1:0] ac;
    } core_state_t;

    core_state_t s_d, s_q;

    logic [N_STEPS-1:0]   t;
    logic [N_OPCODES-1:0] d;
    logic                 sc_clr;
    logic                 core_we;
    logic [WORD_W-1:0]    core_wdata;
    logic                 mem_we;
    logic [ADDR_W-1:0]    mem_waddr;
    logic [WORD_W-1:0]    mem_wdata;
    logic [WORD_W-1:0]    mem_rd;
    logic                 rr_d, io_d;

    acc_seq_timer #(.N_STEPS(N_STEPS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (s_q.run),
        .clear   (sc_clr),
        .sc      (step),
        .t       (t)
    );

    acc_seq_opdec u_opdec (
        .op (s_q.ir[OP_HI:OP_LO]),
        .d  (d)
    );

    acc_seq_mem #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_mem (
        .clk     (clk),
        .we      (mem_we),
        .waddr   (mem_waddr),
        .wdata   (mem_wdata),
        .raddr_a (s_q.ar),
        .rdata_a (mem_rd),
        .raddr_b (host_addr),
        .rdata_b (host_rdata)
    );

    always_comb begin
        s_d        = s_q;
        sc_clr     = 1'b0;
        core_we    = 1'b0;
        core_wdata = '0;
        rr_d       = 1'b0;
        io_d       = 1'b0;

        if (stop) begin
            s_d.run = 1'b0;
        end else if (start) begin
            s_d.run = 1'b1;
        end

        if (s_q.run) begin
            if (t[0]) begin
                s_d.ar = s_q.pc;
            end else if (t[1]) begin
                s_d.ir = mem_rd;
                s_d.pc = s_q.pc + 1'b1;
            end else if (t[2]) begin
                s_d.ar  = s_q.ir[ADDR_W-1:0];
                s_d.ind = s_q.ir[IND_BIT];
            end else if (t[3]) begin
                if (d[OP_EXT]) begin
                    sc_clr = 1'b1;
                    rr_d   = ~s_q.ind;
                    io_d   = s_q.ind;
                end else if (s_q.ind) begin
                    s_d.ar = mem_rd[ADDR_W-1:0];
                end
            end else if (t[4]) begin
                if (d[OP_AND] | d[OP_ADD] | d[OP_LDA] | d[OP_ISZ]) begin
                    s_d.dr = mem_rd;
                end
                if (d[OP_STA]) begin
                    core_we    = 1'b1;
                    core_wdata = s_q.ac;
                    sc_clr     = 1'b1;
                end
                if (d[OP_BUN]) begin
                    s_d.pc = s_q.ar;
                    sc_clr = 1'b1;
                end
                if (d[OP_BSA]) begin
                    core_we    = 1'b1;
                    core_wdata = {{PAD_W{1'b0}}, s_q.pc};
                    s_d.ar     = s_q.ar + 1'b1;
                end
            end else if (t[5]) begin
                if (d[OP_AND]) begin
                    s_d.ac = s_q.ac & s_q.dr;
                    sc_clr = 1'b1;
                end
                if (d[OP_ADD]) begin
                    {s_d.e, s_d.ac} = {1'b0, s_q.ac} + {1'b0, s_q.dr};
                    sc_clr = 1'b1;
                end
                if (d[OP_LDA]) begin
                    s_d.ac = s_q.dr;
                    sc_clr = 1'b1;
                end
                if (d[OP_BSA]) begin
                    s_d.pc = s_q.ar;
                    sc_clr = 1'b1;
                end
                if (d[OP_ISZ]) begin
                    s_d.dr = s_q.dr + 1'b1;
                end
            end else if (t[6]) begin
                core_we    = 1'b1;
                core_wdata = s_q.dr;
                sc_clr     = 1'b1;
                if (s_q.dr == '0) begin
                    s_d.pc = s_q.pc + 1'b1;
                end
            end
        end
    end

    always_comb begin
        if (s_q.run) begin
            mem_we    = core_we;
            mem_waddr = s_q.ar;
            mem_wdata = core_wdata;
        end else begin
            mem_we    = host_we;
            mem_waddr = host_addr;
            mem_wdata = host_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign running    = s_q.run;
    assign pc         = s_q.pc;
    assign ac         = s_q.ac;
    assign e_flag     = s_q.e;
    assign ir         = s_q.ir;
    assign regref_stb = rr_d;
    assign io_stb     = io_d;
endmodule

// File: rtl/acc_seq_chk.sv
module acc_seq_chk #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned SC_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              running,
    input logic [SC_W-1:0]   step,
    input logic [ADDR_W-1:0] pc,
    input logic [WORD_W-1:0] ac,
    input logic              e_flag,
    input logic [2:0]        op,
    input logic              regref_stb,
    input logic              io_stb
);
    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> ($stable(pc) && $stable(ac) && $stable(step) && $stable(e_flag))); // R2

    AST_FETCH_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (running && step == SC_W'(1)) |=> (pc == $past(pc) + 1'b1)); // R3

    AST_STEP_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        step <= SC_W'(6)); // R3

    AST_T6_ONLY_ISZ: assert property (@(posedge clk) disable iff (!rst_n)
        (step == SC_W'(6)) |-> (op == 3'd6)); // R8

    AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(regref_stb && io_stb)); // R9

    AST_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (regref_stb || io_stb) |=> !(regref_stb || io_stb)); // R9

    AST_STB_WHEN: assert property (@(posedge clk) disable iff (!rst_n)
        (regref_stb || io_stb) |-> (step == SC_W'(3) && op == 3'd7)); // R9

    AST_EXT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (running && step == SC_W'(3) && op == 3'd7) |=> (step == '0)); // R9
endmodule

bind acc_seq acc_seq_chk #(
    .WORD_W (WORD_W),
    .ADDR_W (ADDR_W),
    .SC_W   ($clog2(N_STEPS))
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .running    (running),
    .step       (step),
    .pc         (pc),
    .ac         (ac),
    .e_flag     (e_flag),
    .op         (ir[WORD_W-2:WORD_W-4]),
    .regref_stb (regref_stb),
    .io_stb     (io_stb)
);

// File: tb/acc_seq_bench.sv
`timescale 1ns/1ps
module acc_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        stop = 1'b0;
    logic        host_we = 1'b0;
    logic [11:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        running;
    logic [2:0]  step;
    logic [11:0] pc;
    logic [15:0] ac;
    logic        e_flag;
    logic [15:0] ir;
    logic        regref_stb;
    logic        io_stb;

    always #5 clk = ~clk;

    acc_seq u_acc_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .running(running), .step(step), .pc(pc),
        .ac(ac), .e_flag(e_flag), .ir(ir), .regref_stb(regref_stb), .io_stb(io_stb)
    );

    typedef struct {
        logic [11:0] pc;
        logic [15:0] ac;
        logic        e;
        int          len;
        bit          rr;
        bit          io;
        string       req;
    } exp_t;

    exp_t sb_q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;
    bit   mon_en = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [11:0] p, input logic [15:0] a, input logic e,
                        input int len, input bit rr, input bit io, input string req);
        exp_t it;
        it.pc = p; it.ac = a; it.e = e; it.len = len; it.rr = rr; it.io = io; it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic mem_wr(input logic [11:0] a, input logic [15:0] dta);
        host_addr = a; host_wdata = dta; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    // Monitor: an instruction ends when the step count comes back to 0.
    bit run_prev = 0;
    int cyc = 0;
    bit saw_rr = 0;
    bit saw_io = 0;
    always @(negedge clk) begin
        if (mon_en) begin
            if (run_prev) cyc++;
            if (regref_stb) saw_rr = 1;
            if (io_stb) saw_io = 1;
            if (running && step == 3'd0 && cyc > 0) begin
                if (sb_q.size() > 0) begin
                    exp_t it;
                    it = sb_q.pop_front();
                    check(pc == it.pc, it.req, "pc", 32'(pc), 32'(it.pc));
                    check(ac == it.ac, it.req, "ac", 32'(ac), 32'(it.ac));
                    check(e_flag == it.e, it.req, "e_flag", 32'(e_flag), 32'(it.e));
                    check(cyc == it.len, it.req, "step count", 32'(cyc), 32'(it.len));
                    check(saw_rr == it.rr, it.req, "regref_stb", 32'(saw_rr), 32'(it.rr));
                    check(saw_io == it.io, it.req, "io_stb", 32'(saw_io), 32'(it.io));
                end
                cyc = 0; saw_rr = 0; saw_io = 0;
            end
            run_prev = running;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [11:0] h_pc;
        logic [15:0] h_ac;
        logic [2:0]  h_step;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check(running == 1'b0, "R1", "running", 32'(running), 0);
        check(step == 3'd0, "R1", "step", 32'(step), 0);
        check(pc == 12'd0, "R1", "pc", 32'(pc), 0);
        check(ac == 16'd0 && e_flag == 1'b0, "R1", "ac/e", 32'({e_flag, ac}), 0);

        mem_wr(12'h000, 16'h2100); // LDA 100
        mem_wr(12'h001, 16'h0101); // AND 101
        mem_wr(12'h002, 16'h9102); // ADD indirect 102
        mem_wr(12'h003, 16'h3104); // STA 104
        mem_wr(12'h004, 16'h6105); // ISZ 105 (skips)
        mem_wr(12'h005, 16'h7001); // skipped
        mem_wr(12'h006, 16'h6106); // ISZ 106 (no skip)
        mem_wr(12'h007, 16'h5110); // BSA 110
        mem_wr(12'h111, 16'h7800); // register-class
        mem_wr(12'h112, 16'hF400); // I/O-class
        mem_wr(12'h113, 16'hC107); // BUN indirect 107
        mem_wr(12'h020, 16'hA110); // LDA indirect 110
        mem_wr(12'h021, 16'h1108); // ADD 108
        mem_wr(12'h022, 16'h4022); // BUN to self
        mem_wr(12'h100, 16'h00F0);
        mem_wr(12'h101, 16'h0F3C);
        mem_wr(12'h102, 16'h0103);
        mem_wr(12'h103, 16'hFFE0);
        mem_wr(12'h104, 16'h0000);
        mem_wr(12'h105, 16'hFFFF);
        mem_wr(12'h106, 16'h0005);
        mem_wr(12'h107, 16'h0020);
        mem_wr(12'h108, 16'h0001);
        mem_wr(12'h110, 16'h0000);
        mem_wr(12'h008, 16'h1234);

        host_addr = 12'h101; #1;
        check(host_rdata == 16'h0F3C, "R10", "host read", 32'(host_rdata), 32'h0F3C);

        push(12'h001, 16'h00F0, 1'b0, 6, 0, 0, "R6 lda");
        push(12'h002, 16'h0030, 1'b0, 6, 0, 0, "R5 and");
        push(12'h003, 16'h0010, 1'b1, 6, 0, 0, "R4 R5 add indirect carry");
        push(12'h004, 16'h0010, 1'b1, 5, 0, 0, "R6 sta");
        push(12'h006, 16'h0010, 1'b1, 7, 0, 0, "R8 isz skip");
        push(12'h007, 16'h0010, 1'b1, 7, 0, 0, "R8 isz no skip");
        push(12'h111, 16'h0010, 1'b1, 6, 0, 0, "R7 bsa");
        push(12'h112, 16'h0010, 1'b1, 4, 1, 0, "R9 register-class");
        push(12'h113, 16'h0010, 1'b1, 4, 0, 1, "R9 io-class");
        push(12'h020, 16'h0010, 1'b1, 5, 0, 0, "R4 R7 bun indirect");
        push(12'h021, 16'h1234, 1'b1, 6, 0, 0, "R4 R6 lda indirect");
        push(12'h022, 16'h1235, 1'b0, 6, 0, 0, "R5 add no carry");
        push(12'h022, 16'h1235, 1'b0, 5, 0, 0, "R3 R7 bun self");

        mon_en = 1;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check(running == 1'b1, "R2", "running after start", 32'(running), 1);
        while (sb_q.size() > 0) @(negedge clk);

        mem_wr(12'h108, 16'hAAAA); // must be ignored while running (R10)
        @(negedge clk) stop = 1'b1;
        @(negedge clk) stop = 1'b0;
        mon_en = 0;
        check(running == 1'b0, "R2", "running after stop", 32'(running), 0);
        h_pc = pc; h_ac = ac; h_step = step;
        repeat (10) @(negedge clk);
        check(pc == h_pc && ac == h_ac && step == h_step, "R2", "hold while stopped",
              32'({step, pc}), 32'({h_step, h_pc}));

        host_addr = 12'h108; #1;
        check(host_rdata == 16'h0001, "R10", "write ignored when running", 32'(host_rdata), 32'h0001);
        host_addr = 12'h104; #1;
        check(host_rdata == 16'h0010, "R6", "stored word", 32'(host_rdata), 32'h0010);
        host_addr = 12'h105; #1;
        check(host_rdata == 16'h0000, "R8", "isz wrap write-back", 32'(host_rdata), 0);
        host_addr = 12'h106; #1;
        check(host_rdata == 16'h0006, "R8", "isz write-back", 32'(host_rdata), 6);
        host_addr = 12'h110; #1;
        check(host_rdata == 16'h0008, "R7", "saved return", 32'(host_rdata), 8);

        @(negedge clk) begin start = 1'b1; stop = 1'b1; end
        @(negedge clk) begin start = 1'b0; stop = 1'b0; end
        check(running == 1'b0, "R2", "stop wins over start", 32'(running), 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule